// File: doc/BRIEF.md
# Sequence-Ordered Trace Load/Store Queue

This block is the memory-ordering checker for an in-order backend that replays a trace whose instructions were already reordered by a wider out-of-order engine. Every memory operation in such a trace is tagged with its program-order index among the trace's memory operations. When a trace begins, the queue reserves one slot per memory operation. Slots are indexed by that program-order tag, so the slot order is program order no matter how the replayed schedule issues the operations.

As each memory operation executes, its tag, direction (load or store) and the word span it touches are written into its slot. When a store executes, the queue looks only at slots with a higher tag that have already executed as loads. If any of their word spans overlaps the store's span, the load read memory too early. The trace is then flagged as failed, and the queue drops everything it holds. A trace commit empties the queue in one cycle. A trace start that does not fit the free capacity is refused with a capacity-error pulse. Cache access, store-to-load forwarding and the recovery that follows a violation belong to other blocks.

Top module: `seqord_lsq`

## Requirements
- R1: After synchronous active-low reset, `held_o` is 0 and `viol_o` and `cap_err_o` are 0.
- R2: A start while no slots are held, with `start_count_i` at most DEPTH (32), is accepted. From the next cycle `held_o` equals the count and `cap_err_o` stays 0. A count of exactly DEPTH is accepted.
- R3: A start with a count above DEPTH, or a start while `held_o` is nonzero, is refused. `cap_err_o` is 1 for the one cycle after it, and `held_o` is unchanged.
- R4: A store whose word span overlaps the span of a load with a higher sequence number that has already executed sets `viol_o` for the one cycle after the store. From that cycle `held_o` is 0.
- R5: A load never raises `viol_o`. A store checks only loads that have already executed, so a younger load that executes after the store causes no violation.
- R6: Loads with a sequence number lower than or equal to the store's never cause a violation.
- R7: Overlap is judged on 4-byte words, which are the address with bits [1:0] dropped. Addresses in the same word overlap. Addresses in different words do not.
- R8: An access covers bytes `addr` to `addr + 2**size - 1`, with `exec_size_i` 0/1/2/3 meaning 1/2/4/8 bytes. A misaligned access therefore covers every word it touches.
- R9: A commit without a start in the same cycle sets `held_o` to 0 on the next cycle, and it forgets every recorded execution. An execute in the same cycle as a commit is dropped.
- R10: After a violation, executes are ignored until the next accepted start, and no second violation can follow.
- R11: An execute whose sequence number is not below `held_o` is ignored and recorded nowhere.
- R12: A store does not raise a violation against younger executed stores, only against younger executed loads.
- R13: A start takes priority over a commit or an execute in the same cycle, and those are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Trace start |
| start_count_i | input | 6 | Number of memory operations in the starting trace |
| commit_i | input | 1 | Trace commit |
| exec_valid_i | input | 1 | A memory operation executes this cycle |
| exec_seq_i | input | 5 | Program-order sequence number of the executing operation |
| exec_store_i | input | 1 | 1 = store, 0 = load |
| exec_addr_i | input | 32 | Byte address of the access |
| exec_size_i | input | 2 | Access size as log2 of the byte count |
| viol_o | output | 1 | Ordering violation, one-cycle pulse |
| cap_err_o | output | 1 | Trace start refused, one-cycle pulse |
| held_o | output | 6 | Number of slots reserved by the current trace |

## Verification
The assertions assume that at most one memory operation executes per cycle. They also assume an access never wraps past the top of the address space. The stimulus drives one execute at a time and keeps every address far below the wrap point. The bench creates same-cycle start/commit/execute collisions only on purpose, to check the stated priority. It uses out-of-range sequence numbers only where R11 is under test.

// File: rtl/lsq_pkg.sv
// Shared definitions for the sequence-ordered load/store queue.
// Assumes byte addressing with 4-byte words as the alias granule.
package lsq_pkg;

    // Number of low address bits dropped to form a word address.
    localparam int unsigned LSQ_WORD_SHIFT = 2;

    // Access size encoding: log2 of the byte count.
    typedef enum logic [1:0] {
        LSQ_SZ_1B = 2'd0,
        LSQ_SZ_2B = 2'd1,
        LSQ_SZ_4B = 2'd2,
        LSQ_SZ_8B = 2'd3
    } lsq_size_e;

endpackage

// File: rtl/lsq_slot_bank.sv
// Slot storage for the queue: one slot per program-order sequence number.
// Each slot remembers whether its operation executed, whether it was a load,
// and the first and last word it touched. Every slot compares a probe word
// span against its own span and reports an executed-load overlap.
// Assumes clr_i has priority over wr_i in the same cycle.
module lsq_slot_bank #(
    parameter int DEPTH  = 32,
    parameter int IDX_W  = 5,
    parameter int WORD_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic              wr_load_i,
    input  logic [WORD_W-1:0] wr_lo_i,
    input  logic [WORD_W-1:0] wr_hi_i,
    input  logic [WORD_W-1:0] probe_lo_i,
    input  logic [WORD_W-1:0] probe_hi_i,
    output logic [DEPTH-1:0]  load_hit_o
);

    logic [DEPTH-1:0] done_q;
    logic [DEPTH-1:0] load_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [WORD_W-1:0] lo_q;
        logic [WORD_W-1:0] hi_q;

        // Record or forget the execution state of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                done_q[g] <= 1'b0;
                load_q[g] <= 1'b0;
                lo_q      <= '0;
                hi_q      <= '0;
            end else if (wr_i && (wr_idx_i == IDX_W'(g))) begin
                done_q[g] <= 1'b1;
                load_q[g] <= wr_load_i;
                lo_q      <= wr_lo_i;
                hi_q      <= wr_hi_i;
            end
        end

        // Flag an executed load whose word span overlaps the probe span.
        always_comb begin
            load_hit_o[g] = done_q[g] && load_q[g] &&
                            (lo_q <= probe_hi_i) && (probe_lo_i <= hi_q);
        end
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (load_hit_o == '0)); // R9

endmodule

// File: rtl/lsq_younger_filter.sv
// Keeps only the hits from slots strictly younger (higher sequence number)
// than the probing operation and reduces them to one alias flag.
// Assumes hit_i is already restricted to executed loads.
module lsq_younger_filter #(
    parameter int DEPTH = 32,
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] seq_i,
    input  logic [DEPTH-1:0] hit_i,
    output logic             alias_o
);

    logic [DEPTH-1:0] younger;

    for (genvar g = 0; g < DEPTH; g++) begin : g_mask
        // Slot g is younger when its index exceeds the probing sequence number.
        always_comb younger[g] = (IDX_W'(g) > seq_i);
    end

    // Any surviving hit is an ordering violation.
    always_comb alias_o = |(hit_i & younger);

endmodule

// File: rtl/seqord_lsq.sv
// Sequence-ordered load/store queue for replaying a statically reordered
// trace on an in-order backend. A trace start reserves slots 0..count-1,
// and each operation writes the slot named by its program-order number.
// A store checks younger, already-executed loads for word overlap.
// Assumes one execute per cycle. Priority: start > commit > execute.
module seqord_lsq #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [$clog2(DEPTH+1)-1:0]  start_count_i,
    input  logic                        commit_i,
    input  logic                        exec_valid_i,
    input  logic [$clog2(DEPTH)-1:0]    exec_seq_i,
    input  logic                        exec_store_i,
    input  logic [ADDR_W-1:0]           exec_addr_i,
    input  logic [1:0]                  exec_size_i,
    output logic                        viol_o,
    output logic                        cap_err_o,
    output logic [$clog2(DEPTH+1)-1:0]  held_o
);
    import lsq_pkg::*;

    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int WORD_W = ADDR_W - int'(LSQ_WORD_SHIFT);

    logic [CNT_W-1:0]  held_q;
    logic              viol_q;
    logic              cap_q;
    logic              start_ok;
    logic              in_range;
    logic              do_exec;
    logic              alias_hit;
    logic              clr;
    logic              wr;
    lsq_size_e         sz;
    logic [ADDR_W-1:0] last_byte;
    logic [WORD_W-1:0] span_lo;
    logic [WORD_W-1:0] span_hi;
    logic [DEPTH-1:0]  load_hit;

    // Decide admission, execute eligibility and slot clearing.
    always_comb begin
        start_ok  = (held_q == '0) && (start_count_i <= CNT_W'(DEPTH));
        in_range  = ({1'b0, exec_seq_i} < held_q);
        do_exec   = exec_valid_i && !start_i && !commit_i && in_range;
        clr       = (start_i && start_ok) || (!start_i && commit_i) ||
                    (do_exec && exec_store_i && alias_hit);
        wr        = do_exec && !(exec_store_i && alias_hit);
    end

    // Convert the byte range of the access into a first and last word.
    always_comb begin
        sz        = lsq_size_e'(exec_size_i);
        last_byte = exec_addr_i + ((ADDR_W'(1) << sz) - ADDR_W'(1));
        span_lo   = WORD_W'(exec_addr_i >> LSQ_WORD_SHIFT);
        span_hi   = WORD_W'(last_byte >> LSQ_WORD_SHIFT);
    end

    lsq_slot_bank #(
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W),
        .WORD_W (WORD_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .wr_i       (wr),
        .wr_idx_i   (exec_seq_i),
        .wr_load_i  (!exec_store_i),
        .wr_lo_i    (span_lo),
        .wr_hi_i    (span_hi),
        .probe_lo_i (span_lo),
        .probe_hi_i (span_hi),
        .load_hit_o (load_hit)
    );

    lsq_younger_filter #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_young (
        .seq_i   (exec_seq_i),
        .hit_i   (load_hit),
        .alias_o (alias_hit)
    );

    // Track reserved slots and produce the one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
            viol_q <= 1'b0;
            cap_q  <= 1'b0;
        end else begin
            viol_q <= 1'b0;
            cap_q  <= 1'b0;
            if (start_i) begin
                if (start_ok) held_q <= start_count_i;
                else          cap_q  <= 1'b1;
            end else if (commit_i) begin
                held_q <= '0;
            end else if (do_exec && exec_store_i && alias_hit) begin
                held_q <= '0;
                viol_q <= 1'b1;
            end
        end
    end

    assign viol_o    = viol_q;
    assign cap_err_o = cap_q;
    assign held_o    = held_q;

    AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && held_o == '0 && start_count_i <= CNT_W'(DEPTH))
        |=> (held_o == $past(start_count_i) && !cap_err_o)); // R2
    AST_HELD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        held_o <= CNT_W'(DEPTH)); // R2
    AST_REJECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && held_o != '0) |=> (cap_err_o && held_o == $past(held_o))); // R3
    AST_REJECT_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && start_count_i > CNT_W'(DEPTH)) |=> cap_err_o); // R3
    AST_VIOL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (held_o == '0)); // R4
    AST_LOAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid_i && !exec_store_i) |=> !viol_o); // R5
    AST_COMMIT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !start_i) |=> (held_o == '0 && !viol_o)); // R9
    AST_NO_REPEAT_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |=> !viol_o); // R10
    AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !viol_o); // R13

endmodule

// File: tb/seqord_lsq_tb.sv
// Scoreboard bench: the driver applies one cycle of stimulus, advances a
// requirement-level model and queues the expected outputs; the monitor
// pops each expectation after the following clock edge and compares.
module seqord_lsq_tb;

    localparam int DEPTH = 32;

    typedef struct {
        bit    viol;
        bit    cap;
        int    held;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  start_count_i = '0;
    logic        commit_i = 1'b0;
    logic        exec_valid_i = 1'b0;
    logic [4:0]  exec_seq_i = '0;
    logic        exec_store_i = 1'b0;
    logic [31:0] exec_addr_i = '0;
    logic [1:0]  exec_size_i = '0;
    logic        viol_o;
    logic        cap_err_o;
    logic [5:0]  held_o;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];

    bit          m_done[DEPTH];
    bit          m_load[DEPTH];
    logic [29:0] m_lo[DEPTH];
    logic [29:0] m_hi[DEPTH];
    int          m_held = 0;

    always #10 clk = ~clk;

    seqord_lsq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .start_count_i (start_count_i),
        .commit_i      (commit_i),
        .exec_valid_i  (exec_valid_i),
        .exec_seq_i    (exec_seq_i),
        .exec_store_i  (exec_store_i),
        .exec_addr_i   (exec_addr_i),
        .exec_size_i   (exec_size_i),
        .viol_o        (viol_o),
        .cap_err_o     (cap_err_o),
        .held_o        (held_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin
            m_done[i] = 1'b0;
            m_load[i] = 1'b0;
        end
    endtask

    // Drive one cycle and queue what the requirements predict after the edge.
    task automatic step(input bit st, input int cnt, input bit cm, input bit ev,
                        input int seq, input bit is_st, input logic [31:0] addr,
                        input int sz, input string tag);
        exp_t e;
        logic [31:0] last;
        logic [29:0] lo;
        logic [29:0] hi;
        bit hit;
        @(negedge clk);
        start_i = st; start_count_i = 6'(cnt); commit_i = cm;
        exec_valid_i = ev; exec_seq_i = 5'(seq); exec_store_i = is_st;
        exec_addr_i = addr; exec_size_i = 2'(sz);
        last = addr + (32'd1 << sz) - 32'd1;
        lo = addr[31:2];
        hi = last[31:2];
        e.viol = 1'b0; e.cap = 1'b0; e.tag = tag;
        if (st) begin
            if (m_held != 0 || cnt > DEPTH) e.cap = 1'b1;
            else begin m_held = cnt; model_clear(); end
        end else if (cm) begin
            m_held = 0; model_clear();
        end else if (ev && seq < m_held) begin
            hit = 1'b0;
            if (is_st)
                for (int g = seq + 1; g < DEPTH; g++)
                    if (m_done[g] && m_load[g] && m_lo[g] <= hi && lo <= m_hi[g]) hit = 1'b1;
            if (hit) begin
                e.viol = 1'b1; m_held = 0; model_clear();
            end else begin
                m_done[seq] = 1'b1; m_load[seq] = !is_st; m_lo[seq] = lo; m_hi[seq] = hi;
            end
        end
        e.held = m_held;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 32'h0, 0, tag);
    endtask

    // Monitor: compare each queued expectation a quarter period after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "viol_o", int'(viol_o), int'(e.viol));
                check(e.tag, "cap_err_o", int'(cap_err_o), int'(e.cap));
                check(e.tag, "held_o", int'(held_o), e.held);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "held_o", int'(held_o), 0);
        check("R1", "viol_o", int'(viol_o), 0);
        check("R1", "cap_err_o", int'(cap_err_o), 0);
        idle("R1");

        // R2 accept, R5 load first, R4/R7 store to same word raises violation.
        step(1, 4, 0, 0, 0, 0, 32'h0, 0, "R2");
        step(0, 0, 0, 1, 3, 0, 32'h100, 2, "R5");
        step(0, 0, 0, 1, 1, 1, 32'h102, 0, "R4_R7");
        // R10: executes after a violation are ignored.
        step(0, 0, 0, 1, 0, 1, 32'h100, 2, "R10");
        step(0, 0, 0, 1, 2, 0, 32'h100, 2, "R10");
        // R3 oversize, R2 exact capacity, R3 busy.
        step(1, 40, 0, 0, 0, 0, 32'h0, 0, "R3");
        step(1, 32, 0, 0, 0, 0, 32'h0, 0, "R2");
        step(1, 1, 0, 0, 0, 0, 32'h0, 0, "R3");
        // R6 older load, R7 neighbouring word, R8 misaligned span.
        step(0, 0, 0, 1, 5, 0, 32'h200, 2, "R6");
        step(0, 0, 0, 1, 6, 1, 32'h200, 2, "R6");
        step(0, 0, 0, 1, 5, 1, 32'h200, 2, "R6");
        step(0, 0, 0, 1, 2, 1, 32'h204, 2, "R7");
        step(0, 0, 0, 1, 10, 0, 32'h1FE, 2, "R8");
        step(0, 0, 0, 1, 9, 1, 32'h1FC, 0, "R8");
        idle("R4");

        // R12 younger store, R11 out-of-range execute, R9 commit with execute.
        step(1, 8, 0, 0, 0, 0, 32'h0, 0, "R2");
        step(0, 0, 0, 1, 3, 1, 32'h300, 2, "R12");
        step(0, 0, 0, 1, 1, 1, 32'h300, 2, "R12");
        step(0, 0, 0, 1, 4, 0, 32'h400, 2, "R9");
        step(0, 0, 0, 1, 20, 0, 32'h500, 2, "R11");
        step(0, 0, 0, 1, 8, 0, 32'h500, 2, "R11");
        step(0, 0, 0, 1, 0, 1, 32'h500, 2, "R11");
        step(0, 0, 1, 1, 0, 1, 32'h400, 2, "R9");
        step(1, 8, 0, 0, 0, 0, 32'h0, 0, "R9");
        step(0, 0, 0, 1, 0, 1, 32'h400, 2, "R9");
        // R13: start beats execute and commit in the same cycle.
        step(0, 0, 0, 1, 7, 0, 32'h600, 2, "R13");
        step(1, 2, 1, 1, 6, 1, 32'h600, 2, "R13");
        step(0, 0, 0, 1, 6, 1, 32'h603, 0, "R4");
        // R4 with the highest slot of a full trace, R8 two-byte span.
        step(0, 0, 1, 0, 0, 0, 32'h0, 0, "R9");
        step(1, 32, 0, 0, 0, 0, 32'h0, 0, "R2");
        step(0, 0, 0, 1, 31, 0, 32'h804, 0, "R4");
        step(0, 0, 0, 1, 0, 1, 32'h803, 1, "R8");
        // R5: a younger load executing after the store does not fire.
        step(1, 4, 0, 0, 0, 0, 32'h0, 0, "R2");
        step(0, 0, 0, 1, 0, 1, 32'h700, 2, "R5");
        step(0, 0, 0, 1, 2, 0, 32'h700, 2, "R5");
        step(0, 0, 1, 0, 0, 0, 32'h0, 0, "R9");
        idle("R1");

        repeat (3) @(posedge clk);
        check("R1", "scoreboard drained", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule